// File: doc/BRIEF.md
# Three-Mode Serial Port

This block is a serial port whose single datapath runs in one of three modes, chosen by a two-bit mode field. Mode 0 is a synchronous shift register: one pin carries data in both directions and a second pin supplies the shift clock at one sixteenth of the system clock. Modes 1 and 2 are asynchronous. Mode 1 sends and receives a 10-bit frame at a rate set by an external tick input. Mode 2 sends and receives an 11-bit frame with a software-chosen ninth bit, at one sixteenth or one thirty-second of the system clock.

Software loads a byte, plus a ninth bit for mode 2, with a one-cycle load pulse. Transmit-done and receive-done flags stay set until software clears them. A received frame delivers the byte and a ninth-bit value. In mode 1 the ninth-bit value is the stop bit. In mode 2 it is the ninth data bit. A missing stop bit sets a framing-error flag. The asynchronous receiver counts 16 sub-bit ticks per bit and requires the start bit to still be low at mid-bit before it accepts a frame.

Top module: `serial_port_multi`

## Requirements
- R1: After reset, tx_done, rx_done, frame_err, rx_byte and rx_bit9 are 0, clk_tx_pin_o and dat_pin_o are 1, and dat_pin_oe is 0.
- R2: With mode_sel = 0, a tx_load pulse shifts the byte out on dat_pin_o with dat_pin_oe = 1, bit 0 first, 8 bits. Each bit lasts 16 clocks. During each bit, clk_tx_pin_o is low for the first 8 clocks and high for the last 8. Data changes only as clk_tx_pin_o falls, and tx_done sets after the eighth bit.
- R3: With mode_sel = 0, rx_en = 1, rx_done = 0 and the port idle, a reception starts. It samples dat_pin_i at each rise of clk_tx_pin_o, bit 0 first. After 8 bits it sets rx_done and presents the byte on rx_byte.
- R4: With mode_sel = 1, a load sends on clk_tx_pin_o a 0 start bit, 8 data bits LSB first and a 1 stop bit. Each bit lasts 16 baud_tick pulses.
- R5: With mode_sel = 2, a load sends a 0 start bit, 8 data bits LSB first, tx_bit9 and a 1 stop bit. Each bit lasts 16 clocks when rate_half = 1 and 32 clocks when rate_half = 0.
- R6: tx_done rises when the stop bit begins and stays 1 until a clr_tx pulse.
- R7: In mode 1 reception, rx_bit9 receives the stop bit and rx_byte receives the data bits.
- R8: In mode 2 reception, rx_bit9 receives the ninth bit and the stop bit is not stored.
- R9: A 0 sampled in the stop-bit position sets frame_err together with rx_done. A clr_rx pulse clears both.
- R10: A low pulse on dat_pin_i shorter than half a bit is rejected and produces no rx_done.
- R11: A tx_load pulse while a frame is being sent is ignored. The frame in progress is unchanged and no second frame follows.
- R12: rx_done stays 1 until a clr_rx pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0 synchronous, 1 ten-bit asynchronous, 2 eleven-bit asynchronous |
| rate_half | input | 1 | Mode 2 rate: 1 gives clk/16, 0 gives clk/32 |
| baud_tick | input | 1 | Mode 1 sub-bit tick, 16 per bit |
| tx_load | input | 1 | One-cycle pulse that starts a transmission |
| tx_byte | input | DATA_W | Byte to send |
| tx_bit9 | input | 1 | Ninth bit sent in mode 2 |
| rx_en | input | 1 | Receive enable |
| clr_tx | input | 1 | Pulse that clears tx_done |
| clr_rx | input | 1 | Pulse that clears rx_done and frame_err |
| dat_pin_i | input | 1 | Serial input (receive line, or mode 0 data in) |
| dat_pin_o | output | 1 | Mode 0 data out |
| dat_pin_oe | output | 1 | Mode 0 data output enable |
| clk_tx_pin_o | output | 1 | Mode 0 shift clock, or asynchronous transmit line |
| tx_done | output | 1 | Sticky transmit-done flag |
| rx_done | output | 1 | Sticky receive-done flag |
| rx_byte | output | DATA_W | Last received byte |
| rx_bit9 | output | 1 | Received ninth bit or stop bit |
| frame_err | output | 1 | Sticky stop-bit error flag |

## Verification
A wrong bit index or sub-bit counter in the transmitter shows on the line within one bit period, as a shifted or stretched bit at the bench's mid-bit samples. A receiver that latches the wrong sample position yields a wrong rx_byte or rx_bit9 within one frame. Errors in how the ninth bit is steered between stop and data only show when the two modes are compared. A start detector that misses a noise pulse leaves a false rx_done about one frame later. For that reason the bench waits at least that long after each rejected glitch.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic [1:0] {
      SP_SYNC8   = 2'd0,
      SP_ASYNC10 = 2'd1,
      SP_ASYNC11 = 2'd2,
      SP_RSVD    = 2'd3
   } sp_mode_e;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_HUNT  = 2'd1,
      RX_START = 2'd2,
      RX_DATA  = 2'd3
   } sp_rx_st_e;
endpackage

// File: rtl/sp_tick.sv
module sp_tick
   import sp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  sp_mode_e mode,
   input  logic     rate_half,
   input  logic     baud_tick,
   output logic     os_tick
);
   logic div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= 1'b0;
      else        div_q <= ~div_q;
   end

   always_comb begin
      case (mode)
         SP_ASYNC11: os_tick = rate_half ? 1'b1 : div_q;
         SP_SYNC8:   os_tick = 1'b0;
         default:    os_tick = baud_tick;
      endcase
   end
endmodule

// File: rtl/sp_async_tx.sv
module sp_async_tx #(
   parameter int OSR    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              ninth_en,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   input  logic              bit9,
   output logic              line_o,
   output logic              done_o
);
   localparam int FW = DATA_W + 3;
   localparam int CW = $clog2(OSR);
   localparam int IW = $clog2(FW + 1);

   logic [FW-1:0] frame_q;
   logic [IW-1:0] idx_q, last_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '1;
         idx_q   <= '0;
         last_q  <= '0;
         cnt_q   <= '0;
         busy_q  <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!busy_q) begin
            if (load) begin
               frame_q <= ninth_en ? {1'b1, bit9, data, 1'b0} : {2'b11, data, 1'b0};
               last_q  <= ninth_en ? IW'(FW - 1) : IW'(FW - 2);
               idx_q   <= '0;
               cnt_q   <= '0;
               busy_q  <= 1'b1;
            end
         end else if (os_tick) begin
            if (cnt_q == CW'(OSR - 1)) begin
               cnt_q <= '0;
               if (idx_q == last_q) begin
                  busy_q <= 1'b0;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  if (idx_q + 1'b1 == last_q) done_o <= 1'b1;
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign line_o = busy_q ? frame_q[idx_q] : 1'b1;

   AST_DONE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> line_o);                                              // R6
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !busy_q) |=> !line_o);                                  // R4
endmodule

// File: rtl/sp_async_rx.sv
module sp_async_rx
   import sp_pkg::*;
#(
   parameter int OSR    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              enable,
   input  logic              ninth_en,
   input  logic              line,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              bit9_o,
   output logic              ferr_o
);
   localparam int CW = $clog2(OSR);
   localparam int IW = $clog2(DATA_W + 2);

   sp_rx_st_e         st_q;
   logic [CW-1:0]     cnt_q;
   logic [IW-1:0]     idx_q;
   logic [DATA_W:0]   sh_q;
   logic [IW-1:0]     last_w;

   assign last_w = ninth_en ? IW'(DATA_W + 1) : IW'(DATA_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RX_IDLE;
         cnt_q  <= '0;
         idx_q  <= '0;
         sh_q   <= '0;
         done_o <= 1'b0;
         data_o <= '0;
         bit9_o <= 1'b0;
         ferr_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!enable) begin
            st_q <= RX_IDLE;
         end else begin
            case (st_q)
               RX_IDLE: if (line) st_q <= RX_HUNT;
               RX_HUNT: if (os_tick && !line) begin
                  st_q  <= RX_START;
                  cnt_q <= '0;
               end
               RX_START: if (os_tick) begin
                  if (line) begin
                     st_q <= RX_HUNT;
                  end else if (cnt_q == CW'(OSR / 2 - 1)) begin
                     st_q  <= RX_DATA;
                     cnt_q <= '0;
                     idx_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: if (os_tick) begin
                  if (cnt_q == CW'(OSR - 1)) begin
                     cnt_q <= '0;
                     if (idx_q == last_w) begin
                        done_o <= 1'b1;
                        st_q   <= RX_IDLE;
                        data_o <= sh_q[DATA_W-1:0];
                        bit9_o <= ninth_en ? sh_q[DATA_W] : line;
                        ferr_o <= ~line;
                     end else begin
                        sh_q[idx_q] <= line;
                        idx_q       <= idx_q + 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            endcase
         end
      end
   end

   AST_START_FROM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RX_START) |-> ($past(st_q) == RX_HUNT || $past(st_q) == RX_START)); // R10
endmodule

// File: rtl/sp_sync.sv
module sp_sync #(
   parameter int DATA_W = 8,
   parameter int HALF   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_go,
   input  logic              rx_go,
   input  logic [DATA_W-1:0] data,
   input  logic              din,
   output logic              sclk_o,
   output logic              dout_o,
   output logic              doe_o,
   output logic              tx_done_o,
   output logic              rx_done_o,
   output logic [DATA_W-1:0] rx_data_o
);
   localparam int PW = $clog2(2 * HALF);
   localparam int IW = $clog2(DATA_W);

   logic [PW-1:0]     ph_q;
   logic [IW-1:0]     idx_q;
   logic [DATA_W-1:0] sh_q;
   logic              is_tx_q, busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= '0;
         idx_q     <= '0;
         sh_q      <= '0;
         is_tx_q   <= 1'b0;
         busy_q    <= 1'b0;
         tx_done_o <= 1'b0;
         rx_done_o <= 1'b0;
      end else begin
         tx_done_o <= 1'b0;
         rx_done_o <= 1'b0;
         if (!busy_q) begin
            if (tx_go || rx_go) begin
               busy_q  <= 1'b1;
               is_tx_q <= tx_go;
               sh_q    <= tx_go ? data : '0;
               ph_q    <= '0;
               idx_q   <= '0;
            end
         end else begin
            ph_q <= ph_q + 1'b1;
            if (ph_q == PW'(HALF - 1) && !is_tx_q)
               sh_q <= {din, sh_q[DATA_W-1:1]};
            if (ph_q == PW'(2 * HALF - 1)) begin
               ph_q <= '0;
               if (is_tx_q) sh_q <= sh_q >> 1;
               if (idx_q == IW'(DATA_W - 1)) begin
                  busy_q    <= 1'b0;
                  tx_done_o <= is_tx_q;
                  rx_done_o <= ~is_tx_q;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
         end
      end
   end

   assign sclk_o    = busy_q ? (ph_q >= PW'(HALF)) : 1'b1;
   assign dout_o    = (busy_q && is_tx_q) ? sh_q[0] : 1'b1;
   assign doe_o     = busy_q & is_tx_q;
   assign rx_data_o = sh_q;

   AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !$stable(dout_o)) |-> !sclk_o);                      // R2
endmodule

// File: rtl/serial_port_multi.sv
module serial_port_multi
   import sp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_HALF   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic              rate_half,
   input  logic              baud_tick,
   input  logic              tx_load,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tx_bit9,
   input  logic              rx_en,
   input  logic              clr_tx,
   input  logic              clr_rx,
   input  logic              dat_pin_i,
   output logic              dat_pin_o,
   output logic              dat_pin_oe,
   output logic              clk_tx_pin_o,
   output logic              tx_done,
   output logic              rx_done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_bit9,
   output logic              frame_err
);
   if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
      $error("OSR must be a power of two of at least 4");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("DATA_W must be at least 2");
   end
   if (SYNC_HALF < 1) begin : g_bad_half
      $error("SYNC_HALF must be at least 1");
   end

   sp_mode_e mode_e;
   assign mode_e = sp_mode_e'(mode_sel);

   logic din_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign din_s = dat_pin_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sq <= '1;
         else begin
            sq[0] <= dat_pin_i;
            for (int i = 1; i < SYNC_STAGES; i++) sq[i] <= sq[i-1];
         end
      end
      assign din_s = sq[SYNC_STAGES-1];
   end

   logic is_sync, ninth_en, os_tick;
   assign is_sync  = (mode_e == SP_SYNC8);
   assign ninth_en = (mode_e == SP_ASYNC11);

   logic s_sclk, s_dout, s_doe, s_txd, s_rxd;
   logic [DATA_W-1:0] s_data;
   logic a_line, a_txd, a_rxd, a_b9, a_ferr;
   logic [DATA_W-1:0] a_data;

   sp_tick u_tick (
      .clk(clk), .rst_n(rst_n), .mode(mode_e), .rate_half(rate_half),
      .baud_tick(baud_tick), .os_tick(os_tick)
   );

   sp_sync #(.DATA_W(DATA_W), .HALF(SYNC_HALF)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .tx_go(tx_load & is_sync),
      .rx_go(rx_en & ~rx_done & ~tx_load & is_sync),
      .data(tx_byte), .din(din_s),
      .sclk_o(s_sclk), .dout_o(s_dout), .doe_o(s_doe),
      .tx_done_o(s_txd), .rx_done_o(s_rxd), .rx_data_o(s_data)
   );

   sp_async_tx #(.OSR(OSR), .DATA_W(DATA_W)) u_atx (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .ninth_en(ninth_en),
      .load(tx_load & ~is_sync), .data(tx_byte), .bit9(tx_bit9),
      .line_o(a_line), .done_o(a_txd)
   );

   sp_async_rx #(.OSR(OSR), .DATA_W(DATA_W)) u_arx (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
      .enable(rx_en & ~is_sync), .ninth_en(ninth_en), .line(din_s),
      .done_o(a_rxd), .data_o(a_data), .bit9_o(a_b9), .ferr_o(a_ferr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_done   <= 1'b0;
         rx_done   <= 1'b0;
         rx_byte   <= '0;
         rx_bit9   <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         if (s_txd || a_txd) tx_done <= 1'b1;
         else if (clr_tx)    tx_done <= 1'b0;

         if (s_rxd) begin
            rx_done <= 1'b1;
            rx_byte <= s_data;
         end else if (a_rxd) begin
            rx_done   <= 1'b1;
            rx_byte   <= a_data;
            rx_bit9   <= a_b9;
            frame_err <= frame_err | a_ferr;
         end else if (clr_rx) begin
            rx_done   <= 1'b0;
            frame_err <= 1'b0;
         end
      end
   end

   assign dat_pin_o    = is_sync ? s_dout : 1'b1;
   assign dat_pin_oe   = is_sync & s_doe;
   assign clk_tx_pin_o = is_sync ? s_sclk : a_line;

   AST_TXDONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !clr_tx) |=> tx_done);                               // R6
   AST_RXDONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !clr_rx) |=> rx_done);                               // R12
   AST_FERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> rx_done);                                          // R9
   AST_OE_SYNC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      dat_pin_oe |-> (mode_sel == 2'd0));                              // R2
endmodule

// File: tb/serial_port_multi_tb_top.sv
module serial_port_multi_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'd0;
   logic       rate_half = 1'b1;
   logic       baud_tick = 1'b0;
   logic       tx_load = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic       tx_bit9 = 1'b0;
   logic       rx_en = 1'b0;
   logic       clr_tx = 1'b0;
   logic       clr_rx = 1'b0;
   logic       dat_pin_i = 1'b1;
   logic       dat_pin_o, dat_pin_oe, clk_tx_pin_o;
   logic       tx_done, rx_done, rx_bit9, frame_err;
   logic [7:0] rx_byte;

   int n_chk = 0;
   int n_fail = 0;
   int tick_div = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   always @(negedge clk) begin
      tick_div  = (tick_div + 1) % 4;
      baud_tick = (tick_div == 0);
   end

   serial_port_multi dut_i (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rate_half(rate_half),
      .baud_tick(baud_tick), .tx_load(tx_load), .tx_byte(tx_byte),
      .tx_bit9(tx_bit9), .rx_en(rx_en), .clr_tx(clr_tx), .clr_rx(clr_rx),
      .dat_pin_i(dat_pin_i), .dat_pin_o(dat_pin_o), .dat_pin_oe(dat_pin_oe),
      .clk_tx_pin_o(clk_tx_pin_o), .tx_done(tx_done), .rx_done(rx_done),
      .rx_byte(rx_byte), .rx_bit9(rx_bit9), .frame_err(frame_err)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clear_flags();
      @(negedge clk); clr_tx = 1'b1; clr_rx = 1'b1;
      @(negedge clk); clr_tx = 1'b0; clr_rx = 1'b0;
   endtask

   task automatic pulse_load(input logic [7:0] b, input logic b9);
      @(negedge clk); tx_byte = b; tx_bit9 = b9; tx_load = 1'b1;
      @(negedge clk); tx_load = 1'b0;
   endtask

   // R1: reset values
   task automatic t_reset();
      chk(tx_done == 0 && rx_done == 0 && frame_err == 0, "R1 flags", {tx_done, rx_done, frame_err}, 0);
      chk(rx_byte == 0 && rx_bit9 == 0, "R1 rx regs", {rx_bit9, rx_byte}, 0);
      chk(clk_tx_pin_o && dat_pin_o && !dat_pin_oe, "R1 pins", {clk_tx_pin_o, dat_pin_o, dat_pin_oe}, 3'b110);
   endtask

   // R2: mode 0 transmit
   task automatic t_sync_tx(input logic [7:0] b);
      int low_cnt, guard;
      mode_sel = 2'd0; rx_en = 1'b0;
      clear_flags();
      pulse_load(b, 1'b0);
      for (int i = 0; i < 8; i++) begin
         low_cnt = 0;
         while (clk_tx_pin_o == 1'b0 && low_cnt < 40) begin
            low_cnt++;
            @(negedge clk);
         end
         if (i == 0) chk(low_cnt == 8, "R2 low phase", low_cnt, 8);
         chk(dat_pin_o == b[i] && dat_pin_oe, "R2 data bit", {dat_pin_oe, dat_pin_o}, {1'b1, b[i]});
         if (i < 7) begin
            guard = 0;
            while (clk_tx_pin_o == 1'b1 && guard < 40) begin guard++; @(negedge clk); end
         end
      end
      guard = 0;
      while (!tx_done && guard < 40) begin guard++; @(negedge clk); end
      chk(tx_done, "R2 tx_done", tx_done, 1);
      chk(!dat_pin_oe && clk_tx_pin_o, "R2 idle after", {dat_pin_oe, clk_tx_pin_o}, 2'b01);
   endtask

   // R3: mode 0 receive
   task automatic t_sync_rx(input logic [7:0] b);
      int guard;
      mode_sel = 2'd0;
      clear_flags();
      @(negedge clk); rx_en = 1'b1;
      for (int i = 0; i < 8; i++) begin
         guard = 0;
         while (clk_tx_pin_o == 1'b1 && guard < 40) begin guard++; @(negedge clk); end
         dat_pin_i = b[i];
         guard = 0;
         while (clk_tx_pin_o == 1'b0 && guard < 40) begin guard++; @(negedge clk); end
      end
      guard = 0;
      while (!rx_done && guard < 40) begin guard++; @(negedge clk); end
      rx_en = 1'b0; dat_pin_i = 1'b1;
      chk(rx_done, "R3 rx_done", rx_done, 1);
      chk(rx_byte == b, "R3 rx_byte", rx_byte, b);
   endtask

   // R4 R5 R6 R11: asynchronous transmit, sampled at mid-bit
   task automatic t_async_tx(input logic [1:0] m, input logic rh, input logic [7:0] b,
                             input logic b9, input int bl, input bit inject);
      logic [10:0] exp_bits;
      int nb, lows, w;
      mode_sel = m; rate_half = rh;
      nb = (m == 2'd2) ? 11 : 10;
      exp_bits = (m == 2'd2) ? {1'b1, b9, b, 1'b0} : {2'b11, b, 1'b0};
      clear_flags();
      pulse_load(b, b9);
      w = bl / 2;
      for (int k = 0; k < nb; k++) begin
         wait_neg(w);
         w = bl;
         chk(clk_tx_pin_o == exp_bits[k], (m == 2'd2) ? "R5 frame bit" : "R4 frame bit",
             clk_tx_pin_o, exp_bits[k]);
         if (k == nb - 2) chk(!tx_done, "R6 not before stop", tx_done, 0);
         if (k == nb - 1) chk(tx_done, "R6 set in stop", tx_done, 1);
         if (k == 0 && inject) begin
            @(negedge clk); tx_byte = ~b; tx_bit9 = ~b9; tx_load = 1'b1;
            @(negedge clk); tx_load = 1'b0;
            w = bl - 2;
         end
      end
      lows = 0;
      for (int i = 0; i < 2 * bl; i++) begin
         @(negedge clk);
         if (!clk_tx_pin_o) lows++;
      end
      chk(lows == 0, inject ? "R11 no second frame" : "R4 line idle", lows, 0);
      chk(tx_done, "R6 still set", tx_done, 1);
      clear_flags();
      chk(!tx_done, "R6 cleared", tx_done, 0);
   endtask

   task automatic drive_frame(input logic [7:0] b, input logic b9, input logic stp,
                              input bit ninth, input int bl);
      dat_pin_i = 1'b0; wait_neg(bl);
      for (int i = 0; i < 8; i++) begin dat_pin_i = b[i]; wait_neg(bl); end
      if (ninth) begin dat_pin_i = b9; wait_neg(bl); end
      dat_pin_i = stp; wait_neg(bl);
      dat_pin_i = 1'b1;
   endtask

   // R7 R8 R9: asynchronous receive
   task automatic t_async_rx(input logic [1:0] m, input logic [7:0] b, input logic b9,
                             input logic stp, input int bl);
      mode_sel = m; rate_half = 1'b1; rx_en = 1'b1;
      clear_flags();
      wait_neg(bl);
      drive_frame(b, b9, stp, m == 2'd2, bl);
      wait_neg(2 * bl);
      chk(rx_done, (m == 2'd2) ? "R8 rx_done" : "R7 rx_done", rx_done, 1);
      chk(rx_byte == b, (m == 2'd2) ? "R8 rx_byte" : "R7 rx_byte", rx_byte, b);
      if (m == 2'd2) chk(rx_bit9 == b9, "R8 ninth bit", rx_bit9, b9);
      else           chk(rx_bit9 == stp, "R7 stop in rx_bit9", rx_bit9, stp);
      chk(frame_err == ~stp, "R9 frame_err", frame_err, ~stp);
      wait_neg(3 * bl);
      chk(rx_done, "R12 sticky", rx_done, 1);
      clear_flags();
      chk(!rx_done && !frame_err, "R9 R12 cleared", {rx_done, frame_err}, 0);
   endtask

   // R10: short start glitch rejected
   task automatic t_glitch();
      mode_sel = 2'd2; rate_half = 1'b1; rx_en = 1'b1;
      clear_flags();
      wait_neg(20);
      dat_pin_i = 1'b0; wait_neg(4); dat_pin_i = 1'b1;
      wait_neg(12 * 16);
      chk(!rx_done, "R10 glitch ignored", rx_done, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(2);
      t_reset();
      t_sync_tx(8'hA5);
      t_sync_tx(8'h3C);
      t_sync_rx(8'h96);
      t_sync_rx(8'h0F);
      t_async_tx(2'd1, 1'b1, 8'h4B, 1'b0, 64, 1'b0);
      t_async_tx(2'd2, 1'b1, 8'hC3, 1'b1, 16, 1'b0);
      t_async_tx(2'd2, 1'b0, 8'h81, 1'b0, 32, 1'b0);
      t_async_tx(2'd2, 1'b1, 8'h5A, 1'b0, 16, 1'b1);
      t_glitch();
      t_async_rx(2'd2, 8'h3C, 1'b1, 1'b1, 16);
      t_async_rx(2'd2, 8'hE7, 1'b0, 1'b0, 16);
      t_async_rx(2'd1, 8'h6D, 1'b0, 1'b1, 64);
      t_async_rx(2'd1, 8'h12, 1'b0, 1'b0, 64);
      rx_en = 1'b0;
      wait_neg(5);
      finish_run();
   end
endmodule